// File: doc/BRIEF.md
# Bus Target Response and Termination Controller

This block is the slave-side response engine for a target on a PCI-style multiplexed address/data bus. It watches for an address phase, compares the address against one base/mask window, and claims the cycle by asserting its select line. In each data phase it drives its ready line when the local backend can supply or accept a word. A word moves only on a clock where both the target's ready line and the initiator's ready line are low.

The local backend can stop a transaction in two ways. A retry request ends it with no further data. A disconnect request ends it after one more word, which is offered with stop already raised. When the initiator is ready in that same clock, the word moves at once. When the initiator is not ready, the target holds ready and stop until the initiator takes the word. Stop then stays asserted until the initiator raises its frame line.

All bus outputs are active low and registered. Tristate pads, parity, target-abort and configuration cycles are handled outside this block. Read data is loaded into the bus output register when a word is offered. Write data and byte enables are presented to the backend one clock after each transfer.

Top module: `tgt_term_ctrl`

## Requirements
- R1: After a synchronous reset, `tgt_sel_n`, `tgt_ready_n` and `tgt_stop_n` are high, and `lb_wr_valid` and `lb_rd_take` are low.
- R2: An address phase is the first clock with `bus_frame_n` low after a clock where `bus_frame_n` and `ini_ready_n` were both high. If at that clock `bus_cmd[3:1]` is 3'b011 (memory access, `bus_cmd[0]`=1 meaning write) and `((bus_ad_in ^ BASE) & MASK) == 0`, then `tgt_sel_n` goes low on the next clock, `lb_addr` takes the address with its two low bits cleared, and `lb_write` takes `bus_cmd[0]`. Otherwise the select, ready and stop outputs stay high.
- R3: `tgt_ready_n` is first asserted at least one clock after `tgt_sel_n`, and only when `lb_ready` is high. Each transfer during a write gives `lb_wr_valid`=1 on the next clock, with `lb_wr_data` equal to the bus word and `lb_wr_be` equal to the inverted `bus_be_n`. `lb_addr` advances by 4 after each transfer.
- R4: During a read, `lb_rd_take` is high in the same clock in which a new word is taken from `lb_rd_data`. That word appears on `tgt_ad_out` on the next clock and does not change while ready is held.
- R5: A transfer on a clock where `bus_frame_n` is high is the last one. On the next clock `tgt_ready_n` and `tgt_sel_n` go high.
- R6: A retry request (`lb_retry`) with no word on offer raises stop (`tgt_stop_n` low) on the next clock, with `tgt_ready_n` high. No word is transferred after that.
- R7: A disconnect request (`lb_disc`) is remembered until the next word is offered, and that word is offered with `tgt_stop_n` low. If `ini_ready_n` is low in that clock, the word transfers and `tgt_ready_n` goes high on the next clock while stop stays low.
- R8: If a word is offered with stop while `ini_ready_n` is high, `tgt_ready_n` and `tgt_stop_n` both stay low until the word transfers.
- R9: Once low, `tgt_stop_n` stays low while `bus_frame_n` is low. It and `tgt_sel_n` go high on the clock after `bus_frame_n` is seen high with no word pending.
- R10: If `bus_frame_n` and `ini_ready_n` are both high while the target is claiming a transaction, all three bus outputs go high on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_frame_n | input | 1 | Initiator frame, active low |
| ini_ready_n | input | 1 | Initiator ready, active low |
| bus_ad_in | input | DW | Address/data bus as seen by the target |
| bus_cmd | input | 4 | Command in address phase |
| bus_be_n | input | DW/8 | Byte enables in data phases, active low |
| tgt_sel_n | output | 1 | Target claims the cycle, active low |
| tgt_ready_n | output | 1 | Target ready, active low |
| tgt_stop_n | output | 1 | Target requests termination, active low |
| tgt_ad_out | output | DW | Read data for the bus |
| lb_ready | input | 1 | Backend can supply or accept a word |
| lb_rd_data | input | DW | Backend read word |
| lb_retry | input | 1 | Backend retry request |
| lb_disc | input | 1 | Backend disconnect-after-word request |
| lb_rd_take | output | 1 | Read word taken from `lb_rd_data` |
| lb_wr_valid | output | 1 | Write word valid |
| lb_wr_data | output | DW | Write word |
| lb_wr_be | output | DW/8 | Write byte enables, active high |
| lb_addr | output | DW | Current word address |
| lb_write | output | 1 | Transaction is a write |

## Verification
The assertions assume the initiator follows the bus rules. Once it lowers its ready line in a data phase, it keeps it low until a word moves or stop is seen. It raises frame only together with, or before, its final ready. They also assume the backend keeps `lb_ready` meaningful only while the target is claiming a transaction. The stimulus keeps to these assumptions: every table row and directed sequence follows a legal initiator handshake, so frame never rises while the target's ready line is held and the initiator's ready is high. The stimulus also returns the bus to idle before each new address phase.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
  typedef enum logic {ST_IDLE, ST_DATA} tgt_state_t;
  localparam logic [2:0] CMD_MEM_HI = 3'b011;
endpackage

// File: rtl/tgt_addr_decode.sv
module tgt_addr_decode #(
  parameter int unsigned DW = 32,
  parameter logic [DW-1:0] BASE = 32'h8000_0000,
  parameter logic [DW-1:0] MASK = 32'hFFFF_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_frame_n,
  input  logic          ini_ready_n,
  input  logic [DW-1:0] bus_ad_in,
  input  logic [3:0]    bus_cmd,
  output logic          hit_start
);
  import tgt_pkg::*;

  logic prev_frame_n, prev_ready_n;
  logic addr_phase, in_window, cmd_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_frame_n <= 1'b1;
      prev_ready_n <= 1'b1;
    end else begin
      prev_frame_n <= bus_frame_n;
      prev_ready_n <= ini_ready_n;
    end
  end

  assign addr_phase = !bus_frame_n && prev_frame_n && prev_ready_n;
  assign in_window  = ((bus_ad_in ^ BASE) & MASK) == '0;
  assign cmd_ok     = bus_cmd[3:1] == CMD_MEM_HI;
  assign hit_start  = addr_phase && in_window && cmd_ok;
endmodule

// File: rtl/tgt_term_fsm.sv
module tgt_term_fsm (
  input  logic clk,
  input  logic rst,
  input  logic bus_frame_n,
  input  logic ini_ready_n,
  input  logic hit_start,
  input  logic lb_ready,
  input  logic lb_retry,
  input  logic lb_disc,
  output logic sel_q,
  output logic rdy_q,
  output logic stop_q,
  output logic accept,
  output logic xfer,
  output logic load
);
  import tgt_pkg::*;

  tgt_state_t state, nxt_state;
  logic nxt_sel, nxt_rdy, nxt_stop;
  logic pend_retry, pend_disc, rty, dsc, hold;

  assign accept = (state == ST_IDLE) && hit_start;
  assign xfer   = (state == ST_DATA) && rdy_q && !ini_ready_n;
  assign hold   = rdy_q && ini_ready_n;
  assign rty    = pend_retry || lb_retry;
  assign dsc    = pend_disc || lb_disc;

  always_comb begin
    nxt_state = state;
    nxt_sel   = sel_q;
    nxt_rdy   = rdy_q;
    nxt_stop  = stop_q;
    load      = 1'b0;
    case (state)
      ST_IDLE: begin
        nxt_sel  = 1'b0;
        nxt_rdy  = 1'b0;
        nxt_stop = 1'b0;
        if (hit_start) begin
          nxt_state = ST_DATA;
          nxt_sel   = 1'b1;
        end
      end
      ST_DATA: begin
        if (bus_frame_n && ini_ready_n) begin
          nxt_state = ST_IDLE;
          nxt_sel = 1'b0; nxt_rdy = 1'b0; nxt_stop = 1'b0;
        end else if (hold) begin
          nxt_rdy = 1'b1;
        end else if (stop_q) begin
          nxt_rdy = 1'b0;
          if (bus_frame_n) begin
            nxt_state = ST_IDLE;
            nxt_sel = 1'b0; nxt_stop = 1'b0;
          end
        end else if (xfer && bus_frame_n) begin
          nxt_state = ST_IDLE;
          nxt_sel = 1'b0; nxt_rdy = 1'b0;
        end else if (rty) begin
          nxt_stop = 1'b1;
          nxt_rdy  = 1'b0;
        end else if (lb_ready) begin
          nxt_rdy  = 1'b1;
          nxt_stop = dsc;
          load     = 1'b1;
        end else begin
          nxt_rdy = 1'b0;
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sel_q  <= 1'b0;
      rdy_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      state  <= nxt_state;
      sel_q  <= nxt_sel;
      rdy_q  <= nxt_rdy;
      stop_q <= nxt_stop;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || state == ST_IDLE) begin
      pend_retry <= 1'b0;
      pend_disc  <= 1'b0;
    end else begin
      pend_retry <= rty;
      pend_disc  <= dsc;
    end
  end

  assert_claim_on_hit_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_q) |-> $past(hit_start));
  assert_ready_after_sel_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(sel_q));
  assert_last_release_R5: assert property (@(posedge clk) disable iff (rst)
    (rdy_q && !ini_ready_n && bus_frame_n) |=> (!rdy_q && !sel_q));
  assert_no_data_after_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !rdy_q) |=> !rdy_q);
  assert_hold_offer_R8: assert property (@(posedge clk) disable iff (rst)
    (rdy_q && ini_ready_n && !bus_frame_n) |=> rdy_q);
  assert_stop_held_R9: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !bus_frame_n) |=> stop_q);
  assert_idle_release_R10: assert property (@(posedge clk) disable iff (rst)
    (sel_q && bus_frame_n && ini_ready_n) |=> !sel_q);
endmodule

// File: rtl/tgt_datapath.sv
module tgt_datapath #(
  parameter int unsigned DW = 32,
  localparam int unsigned BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          xfer,
  input  logic          load,
  input  logic [DW-1:0] bus_ad_in,
  input  logic          cmd_write,
  input  logic [BW-1:0] bus_be_n,
  input  logic [DW-1:0] lb_rd_data,
  output logic [DW-1:0] rd_out,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data,
  output logic [BW-1:0] wr_be,
  output logic [DW-1:0] addr,
  output logic          is_write
);
  localparam logic [DW-1:0] WORD_STEP = DW'(BW);
  localparam logic [DW-1:0] ALIGN     = ~(WORD_STEP - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr     <= '0;
      is_write <= 1'b0;
    end else if (accept) begin
      addr     <= bus_ad_in & ALIGN;
      is_write <= cmd_write;
    end else if (xfer) begin
      addr <= addr + WORD_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
      wr_be    <= '0;
    end else begin
      wr_valid <= xfer && is_write;
      if (xfer && is_write) begin
        wr_data <= bus_ad_in;
        wr_be   <= ~bus_be_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rd_out <= '0;
    else if (load) rd_out <= lb_rd_data;
  end

  assert_wr_from_xfer_R3: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(xfer));
  assert_rd_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> $stable(rd_out));
endmodule

// File: rtl/tgt_term_ctrl.sv
module tgt_term_ctrl #(
  parameter int unsigned DW = 32,
  parameter logic [DW-1:0] BASE = 32'h8000_0000,
  parameter logic [DW-1:0] MASK = 32'hFFFF_0000,
  localparam int unsigned BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_frame_n,
  input  logic          ini_ready_n,
  input  logic [DW-1:0] bus_ad_in,
  input  logic [3:0]    bus_cmd,
  input  logic [BW-1:0] bus_be_n,
  output logic          tgt_sel_n,
  output logic          tgt_ready_n,
  output logic          tgt_stop_n,
  output logic [DW-1:0] tgt_ad_out,
  input  logic          lb_ready,
  input  logic [DW-1:0] lb_rd_data,
  input  logic          lb_retry,
  input  logic          lb_disc,
  output logic          lb_rd_take,
  output logic          lb_wr_valid,
  output logic [DW-1:0] lb_wr_data,
  output logic [BW-1:0] lb_wr_be,
  output logic [DW-1:0] lb_addr,
  output logic          lb_write
);
  logic hit_start, sel_q, rdy_q, stop_q, accept, xfer, load;

  tgt_addr_decode #(.DW(DW), .BASE(BASE), .MASK(MASK)) u_dec (
    .clk(clk), .rst(rst), .bus_frame_n(bus_frame_n), .ini_ready_n(ini_ready_n),
    .bus_ad_in(bus_ad_in), .bus_cmd(bus_cmd), .hit_start(hit_start)
  );

  tgt_term_fsm u_fsm (
    .clk(clk), .rst(rst), .bus_frame_n(bus_frame_n), .ini_ready_n(ini_ready_n),
    .hit_start(hit_start), .lb_ready(lb_ready), .lb_retry(lb_retry),
    .lb_disc(lb_disc), .sel_q(sel_q), .rdy_q(rdy_q), .stop_q(stop_q),
    .accept(accept), .xfer(xfer), .load(load)
  );

  tgt_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .xfer(xfer), .load(load),
    .bus_ad_in(bus_ad_in), .cmd_write(bus_cmd[0]), .bus_be_n(bus_be_n),
    .lb_rd_data(lb_rd_data), .rd_out(tgt_ad_out), .wr_valid(lb_wr_valid),
    .wr_data(lb_wr_data), .wr_be(lb_wr_be), .addr(lb_addr), .is_write(lb_write)
  );

  assign tgt_sel_n   = ~sel_q;
  assign tgt_ready_n = ~rdy_q;
  assign tgt_stop_n  = ~stop_q;
  assign lb_rd_take  = load && !lb_write;
endmodule

// File: tb/sim_tgt_term_ctrl.sv
`timescale 1ns/1ps
module sim_tgt_term_ctrl;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam logic [DW-1:0] HIT_ADDR  = 32'h8000_0040;
  localparam logic [DW-1:0] MISS_ADDR = 32'h1234_0000;
  // row bits: {hit, frame_n, ini_ready_n, lb_ready, retry, disc, exp_sel_n, exp_ready_n, exp_stop_n}
  localparam int NV = 23;
  localparam logic [8:0] VEC [NV] = '{
    9'b1_011_00_011, 9'b1_001_00_001, 9'b1_001_00_001, 9'b1_101_00_111,
    9'b1_110_00_111, 9'b1_010_00_011, 9'b1_000_10_010, 9'b1_100_00_111,
    9'b1_110_00_111, 9'b1_010_00_011, 9'b1_001_01_000, 9'b1_000_00_010,
    9'b1_100_00_111, 9'b1_110_00_111, 9'b1_010_00_011, 9'b1_011_01_000,
    9'b1_010_00_000, 9'b1_100_00_111, 9'b1_110_00_111, 9'b0_010_00_111,
    9'b0_000_00_111, 9'b0_100_00_111, 9'b0_110_00_111
  };
  localparam int VREQ [NV] = '{2,3,3,5,5,2,6,9,9,2,7,7,9,9,2,8,8,8,9,2,2,2,2};

  logic clk = 1'b0, rst = 1'b1;
  logic bus_frame_n = 1'b1, ini_ready_n = 1'b1;
  logic [DW-1:0] bus_ad_in = '0, lb_rd_data = '0;
  logic [3:0] bus_cmd = 4'b0111;
  logic [BW-1:0] bus_be_n = '0;
  logic lb_ready = 1'b0, lb_retry = 1'b0, lb_disc = 1'b0;
  logic tgt_sel_n, tgt_ready_n, tgt_stop_n, lb_rd_take, lb_wr_valid, lb_write;
  logic [DW-1:0] tgt_ad_out, lb_wr_data, lb_addr;
  logic [BW-1:0] lb_wr_be;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  tgt_term_ctrl #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .bus_frame_n(bus_frame_n), .ini_ready_n(ini_ready_n),
    .bus_ad_in(bus_ad_in), .bus_cmd(bus_cmd), .bus_be_n(bus_be_n),
    .tgt_sel_n(tgt_sel_n), .tgt_ready_n(tgt_ready_n), .tgt_stop_n(tgt_stop_n),
    .tgt_ad_out(tgt_ad_out), .lb_ready(lb_ready), .lb_rd_data(lb_rd_data),
    .lb_retry(lb_retry), .lb_disc(lb_disc), .lb_rd_take(lb_rd_take),
    .lb_wr_valid(lb_wr_valid), .lb_wr_data(lb_wr_data), .lb_wr_be(lb_wr_be),
    .lb_addr(lb_addr), .lb_write(lb_write)
  );

  function automatic string rq(input int k);
    case (k)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      9: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus(input logic f, input logic i);
    bus_frame_n = f;
    ini_ready_n = i;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1", "sel_n", 32'(tgt_sel_n), 32'd1);
    chk("R1", "ready_n", 32'(tgt_ready_n), 32'd1);
    chk("R1", "stop_n", 32'(tgt_stop_n), 32'd1);
    chk("R1", "wr_valid", 32'(lb_wr_valid), 32'd0);
    chk("R1", "rd_take", 32'(lb_rd_take), 32'd0);
    tick();

    // table walk: write command, bus sequences for burst, retry, disconnects, miss
    bus_cmd = 4'b0111;
    for (int k = 0; k < NV; k++) begin
      bus_ad_in = VEC[k][8] ? HIT_ADDR : MISS_ADDR;
      bus(VEC[k][7], VEC[k][6]);
      lb_ready = VEC[k][5];
      lb_retry = VEC[k][4];
      lb_disc  = VEC[k][3];
      tick();
      chk(rq(VREQ[k]), $sformatf("row %0d sel_n", k), 32'(tgt_sel_n), 32'(VEC[k][2]));
      chk(rq(VREQ[k]), $sformatf("row %0d ready_n", k), 32'(tgt_ready_n), 32'(VEC[k][1]));
      chk(rq(VREQ[k]), $sformatf("row %0d stop_n", k), 32'(tgt_stop_n), 32'(VEC[k][0]));
    end
    lb_ready = 1'b0; lb_retry = 1'b0; lb_disc = 1'b0;

    // R2 R3 R5: write burst data, byte enables and address stepping
    bus_cmd = 4'b0111; bus_ad_in = 32'h8000_0013; bus(1'b0, 1'b1);
    tick();
    chk("R2", "addr", lb_addr, 32'h8000_0010);
    chk("R2", "write", 32'(lb_write), 32'd1);
    bus(1'b0, 1'b0); lb_ready = 1'b1; bus_ad_in = 32'hDEAD_0001; bus_be_n = 4'b0000;
    tick();
    chk("R3", "ready_n", 32'(tgt_ready_n), 32'd0);
    tick();
    chk("R3", "wr_valid", 32'(lb_wr_valid), 32'd1);
    chk("R3", "wr_data", lb_wr_data, 32'hDEAD_0001);
    chk("R3", "wr_be", 32'(lb_wr_be), 32'hF);
    chk("R3", "addr step", lb_addr, 32'h8000_0014);
    bus(1'b1, 1'b0); bus_ad_in = 32'hBEEF_0002; bus_be_n = 4'b1100;
    tick();
    chk("R3", "wr_data2", lb_wr_data, 32'hBEEF_0002);
    chk("R3", "wr_be2", 32'(lb_wr_be), 32'h3);
    chk("R5", "ready_n", 32'(tgt_ready_n), 32'd1);
    chk("R5", "sel_n", 32'(tgt_sel_n), 32'd1);
    bus(1'b1, 1'b1); lb_ready = 1'b0;
    tick();

    // R4 read: take pulse, data on bus, stable during wait state
    bus_cmd = 4'b0110; bus_ad_in = HIT_ADDR; bus(1'b0, 1'b1);
    tick();
    chk("R2", "read write flag", 32'(lb_write), 32'd0);
    bus(1'b0, 1'b0); lb_ready = 1'b1; lb_rd_data = 32'hA5A5_1111;
    #1;
    chk("R4", "take", 32'(lb_rd_take), 32'd1);
    tick();
    chk("R4", "ad_out", tgt_ad_out, 32'hA5A5_1111);
    bus(1'b0, 1'b1); lb_rd_data = 32'h5A5A_2222;
    #1;
    chk("R4", "no take while held", 32'(lb_rd_take), 32'd0);
    tick();
    chk("R4", "ad_out stable", tgt_ad_out, 32'hA5A5_1111);
    chk("R4", "ready held", 32'(tgt_ready_n), 32'd0);
    bus(1'b1, 1'b0); lb_ready = 1'b0;
    tick();
    chk("R5", "read release", 32'(tgt_ready_n), 32'd1);
    bus(1'b1, 1'b1);
    tick();

    // R2 non-memory command inside window is ignored
    bus_cmd = 4'b0010; bus_ad_in = HIT_ADDR; bus(1'b0, 1'b1);
    tick();
    chk("R2", "io cmd sel_n", 32'(tgt_sel_n), 32'd1);
    bus(1'b1, 1'b1);
    tick();

    // R7 disconnect request latched while backend not ready
    bus_cmd = 4'b0111; bus(1'b0, 1'b1);
    tick();
    bus(1'b0, 1'b0); lb_ready = 1'b0; lb_disc = 1'b1;
    tick();
    chk("R7", "no offer yet", 32'(tgt_ready_n), 32'd1);
    chk("R7", "no stop yet", 32'(tgt_stop_n), 32'd1);
    lb_disc = 1'b0; lb_ready = 1'b1;
    tick();
    chk("R7", "offer ready_n", 32'(tgt_ready_n), 32'd0);
    chk("R7", "offer stop_n", 32'(tgt_stop_n), 32'd0);
    bus(1'b1, 1'b0); lb_ready = 1'b0;
    tick();
    chk("R9", "stop released", 32'(tgt_stop_n), 32'd1);
    bus(1'b1, 1'b1);
    tick();

    // R10 bus goes idle while claimed
    bus(1'b0, 1'b1);
    tick();
    chk("R10", "claimed", 32'(tgt_sel_n), 32'd0);
    bus(1'b1, 1'b1);
    tick();
    chk("R10", "released sel_n", 32'(tgt_sel_n), 32'd1);
    chk("R10", "released ready_n", 32'(tgt_ready_n), 32'd1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule